// File: doc/BRIEF.md
# Address Breakpoint Comparator Unit

This unit watches a 24-bit CPU address bus and compares it with a bank of break addresses. Each break address has its own enable flag. On a valid bus cycle, if one or more enabled entries equal the bus address, the unit raises a non-maskable interrupt request. It also records the index of the lowest-numbered matching entry. Both stay latched until software reads the status byte. That read returns the index and clears the interrupt and the index together.

Each break address is wider than the 8-bit configuration data path, so it is loaded in pieces. The lower bytes go into one staging register that all entries share. A final write to the chosen entry carries the top byte and commits the whole address in one step. Enable flags are written one at a time through a dedicated selector. Software reaches the status byte with an ordinary read anywhere in the top 256-byte page of the address space, because that location is only partially decoded.

Top module: `addr_watch_unit`

## Requirements
- R1: A write with `cfgSel` = 32 loads staging bits 7:0 and a write with `cfgSel` = 33 loads staging bits 15:8. A write with `cfgSel` = k (k < 32) sets entry k to {`cfgData`, staging} in one step. An entry's break address changes only on its commit write.
- R2: After reset, `nmi` is low, `statusData` is 0 and every enable flag is clear, so no bus address matches.
- R3: A write with `cfgSel` = 34 sets the enable flag of entry `cfgData[4:0]` to `cfgData[7]`. It leaves the other flags and all break addresses unchanged.
- R4: A match requires all three of: `busValid` high, the entry's enable flag set, and all 24 bits of `busAddr` equal to the entry's break address. On a captured match, `nmi` rises after the next rising clock edge.
- R5: `statusData[4:0]` gives the captured entry index in binary: entry 0 reads 00000 and entry 31 reads 11111. `statusData[7:5]` always reads 0, and `statusData` reads 0 while nothing is captured.
- R6: When several enabled entries match in the same cycle, the lowest-numbered one is captured.
- R7: While an index is captured, later matches change neither `nmi` nor `statusData`.
- R8: A valid read (`busRead` high) whose `busAddr[23:16]` and `busAddr[15:8]` are both FFh returns the status byte in that cycle. It clears `nmi` and the index at the next edge. No match is captured in that cycle. Reads elsewhere and writes to that page clear nothing.
- R9: The staging register keeps its contents after a commit, so a second commit that carries only a new top byte reuses the staged lower bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 6 | Configuration selector: entry commit, staging byte or enable register |
| cfgData | input | 8 | Configuration write data |
| busValid | input | 1 | Marks a monitored bus cycle |
| busRead | input | 1 | Monitored cycle is a read |
| busAddr | input | 24 | Monitored bus address |
| nmi | output | 1 | Latched break request |
| statusData | output | 8 | Status byte: captured index on bits 4:0 |

## Verification
The assertions check, on every cycle, the properties that hold whatever the programming: the upper status bits stay zero, the status is zero while no break is pending, and a pending break and its index hold steady until a status read. They also check that every status-page read clears the break, and that the break cannot rise without a valid bus cycle. Only the bench scenarios can show the behaviours that depend on what was programmed. These are the two-step commit through the staging register and its reuse, the full 24-bit compare, the effect of one enable flag, lowest-index priority, and the exact index values at both ends of the bank.

// File: rtl/addr_watch_pkg.sv
package addr_watch_pkg;

  // Strobes from the control decoder into the datapath
  typedef struct packed {
    logic stageWr;   // write one staging byte
    logic commit;    // commit {data, staging} into an entry
    logic enWr;      // write one enable flag
    logic capture;   // latch the winning index
    logic clear;     // status read: drop pending break
  } ctrl_strobe_t;

endpackage

// File: rtl/addr_watch_ctrl.sv
module addr_watch_ctrl
  import addr_watch_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int ADDR_W      = 24,
  parameter int NUM_STAGE   = ADDR_W / 8 - 1,
  parameter int SEL_W       = $clog2(NUM_ENTRIES + NUM_STAGE + 1)
) (
  input  logic              cfgWe,
  input  logic [SEL_W-1:0]  cfgSel,
  input  logic              busValid,
  input  logic              busRead,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              pending,
  input  logic              anyHit,
  output ctrl_strobe_t      strb
);

  localparam int STAGE_BASE = NUM_ENTRIES;
  localparam int EN_SEL     = NUM_ENTRIES + NUM_STAGE;

  logic statusRd;
  logic isStage;

  // Status page is decoded on the upper address bits only
  assign statusRd = busValid && busRead && (&busAddr[ADDR_W-1:8]);
  assign isStage  = (cfgSel >= SEL_W'(STAGE_BASE)) && (cfgSel < SEL_W'(EN_SEL));

  always_comb begin
    strb         = '0;
    strb.stageWr = cfgWe && isStage;
    strb.commit  = cfgWe && (cfgSel < SEL_W'(NUM_ENTRIES));
    strb.enWr    = cfgWe && (cfgSel == SEL_W'(EN_SEL));
    strb.clear   = statusRd;
    strb.capture = busValid && anyHit && !pending && !statusRd;
  end

endmodule

// File: rtl/addr_watch_dp.sv
module addr_watch_dp
  import addr_watch_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int ADDR_W      = 24,
  parameter int NUM_STAGE   = ADDR_W / 8 - 1,
  parameter int IDX_W       = $clog2(NUM_ENTRIES),
  parameter int SEL_W       = $clog2(NUM_ENTRIES + NUM_STAGE + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strb,
  input  logic [SEL_W-1:0]  cfgSel,
  input  logic [7:0]        cfgData,
  input  logic [ADDR_W-1:0] busAddr,
  output logic              anyHit,
  output logic              pending,
  output logic [IDX_W-1:0]  capIdx
);

  localparam int STAGE_W = NUM_STAGE * 8;

  logic [7:0]             stageByte [NUM_STAGE];
  logic [STAGE_W-1:0]     stageFlat;
  logic [SEL_W-1:0]       stageSel;
  logic [ADDR_W-1:0]      barMem [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] enFlags;
  logic [NUM_ENTRIES-1:0] hitVec;
  logic [IDX_W-1:0]       hitIdx;

  assign stageSel = cfgSel - SEL_W'(NUM_ENTRIES);

  // Shared staging bytes
  for (genvar s = 0; s < NUM_STAGE; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                      stageByte[s] <= '0;
      else if (strb.stageWr && stageSel == SEL_W'(s)) stageByte[s] <= cfgData;
    end
    assign stageFlat[s*8 +: 8] = stageByte[s];
  end

  // Break entries and their compare
  for (genvar k = 0; k < NUM_ENTRIES; k++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        barMem[k]  <= '0;
        enFlags[k] <= 1'b0;
      end else begin
        if (strb.commit && cfgSel == SEL_W'(k))
          barMem[k] <= {cfgData, stageFlat};
        if (strb.enWr && cfgData[IDX_W-1:0] == IDX_W'(k))
          enFlags[k] <= cfgData[7];
      end
    end
    assign hitVec[k] = enFlags[k] && (barMem[k] == busAddr);
  end

  assign anyHit = |hitVec;

  // Lowest index wins
  always_comb begin
    hitIdx = '0;
    for (int k = NUM_ENTRIES - 1; k >= 0; k--)
      if (hitVec[k]) hitIdx = IDX_W'(k);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
      capIdx  <= '0;
    end else if (strb.clear) begin
      pending <= 1'b0;
      capIdx  <= '0;
    end else if (strb.capture) begin
      pending <= 1'b1;
      capIdx  <= hitIdx;
    end
  end

endmodule

// File: rtl/addr_watch_unit.sv
module addr_watch_unit
  import addr_watch_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int ADDR_W      = 24,
  parameter int NUM_STAGE   = ADDR_W / 8 - 1,
  parameter int IDX_W       = $clog2(NUM_ENTRIES),
  parameter int SEL_W       = $clog2(NUM_ENTRIES + NUM_STAGE + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [SEL_W-1:0]  cfgSel,
  input  logic [7:0]        cfgData,
  input  logic              busValid,
  input  logic              busRead,
  input  logic [ADDR_W-1:0] busAddr,
  output logic              nmi,
  output logic [7:0]        statusData
);

  ctrl_strobe_t       strb;
  logic               anyHit;
  logic               pending;
  logic [IDX_W-1:0]   capIdx;

  addr_watch_ctrl #(
    .NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W),
    .NUM_STAGE(NUM_STAGE), .SEL_W(SEL_W)
  ) u_ctrl (
    .cfgWe(cfgWe), .cfgSel(cfgSel), .busValid(busValid), .busRead(busRead),
    .busAddr(busAddr), .pending(pending), .anyHit(anyHit), .strb(strb)
  );

  addr_watch_dp #(
    .NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W), .NUM_STAGE(NUM_STAGE),
    .IDX_W(IDX_W), .SEL_W(SEL_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgSel(cfgSel), .cfgData(cfgData),
    .busAddr(busAddr), .anyHit(anyHit), .pending(pending), .capIdx(capIdx)
  );

  assign nmi        = pending;
  assign statusData = 8'(capIdx);

endmodule

// File: rtl/addr_watch_chk.sv
module addr_watch_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busRead,
  input logic [ADDR_W-1:0] busAddr,
  input logic              nmi,
  input logic [7:0]        statusData
);

  logic pageRead;
  assign pageRead = busValid && busRead && (&busAddr[ADDR_W-1:8]);

  // R5: upper status bits are always zero
  a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    statusData[7:5] == 3'b000);

  // R5: nothing pending reads as zero
  a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !nmi |-> statusData == 8'h00);

  // R7: a pending break holds with its index until the status read
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    nmi && !pageRead |=> nmi && $stable(statusData));

  // R8: a status-page read clears the break
  a_r8_clear: assert property (@(posedge clk) disable iff (!rstN)
    pageRead |=> !nmi && statusData == 8'h00);

  // R4: no break appears without a valid bus cycle
  a_r4_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    !nmi && !busValid |=> !nmi);

endmodule

bind addr_watch_unit addr_watch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busRead(busRead),
  .busAddr(busAddr), .nmi(nmi), .statusData(statusData)
);

// File: tb/test_addr_watch_unit.sv
module test_addr_watch_unit;

  localparam int N      = 32;
  localparam int SEL_W  = 6;
  localparam int ST_LO  = N;
  localparam int ST_MID = N + 1;
  localparam int EN_SEL = N + 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgWe = 1'b0;
  logic [SEL_W-1:0]  cfgSel = '0;
  logic [7:0]        cfgData = '0;
  logic              busValid = 1'b0;
  logic              busRead = 1'b0;
  logic [23:0]       busAddr = '0;
  logic              nmi;
  logic [7:0]        statusData;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  addr_watch_unit i_addr_watch_unit (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .busValid(busValid), .busRead(busRead), .busAddr(busAddr),
    .nmi(nmi), .statusData(statusData)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input int sel, input logic [7:0] data);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = SEL_W'(sel); cfgData = data;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic loadBar(input int idx, input logic [23:0] a);
    cfgWrite(ST_LO, a[7:0]);
    cfgWrite(ST_MID, a[15:8]);
    cfgWrite(idx, a[23:16]);
  endtask

  task automatic setEn(input int idx, input bit v);
    cfgWrite(EN_SEL, {v, 2'b00, 5'(idx)});
  endtask

  task automatic busCycle(input logic [23:0] a, input bit rd);
    @(negedge clk);
    busAddr = a; busRead = rd; busValid = 1'b1;
    @(negedge clk);
    busValid = 1'b0; busRead = 1'b0;
  endtask

  task automatic readStatus(input logic [23:0] a, output logic [7:0] v);
    @(negedge clk);
    busAddr = a; busRead = 1'b1; busValid = 1'b1;
    #1 v = statusData;
    @(negedge clk);
    busValid = 1'b0; busRead = 1'b0;
  endtask

  task automatic expectBreak(input string req, input int idx);
    check(nmi === 1'b1, req, int'(nmi), 1);
    check(statusData === 8'(idx), req, int'(statusData), idx);
  endtask

  task automatic expectIdle(input string req);
    check(nmi === 1'b0, req, int'(nmi), 0);
    check(statusData === 8'h00, req, int'(statusData), 0);
  endtask

  task automatic clearBreak();
    logic [7:0] v;
    readStatus(24'hFFFFFF, v);
  endtask

  // R2: reset state, no entry enabled
  task automatic t_reset();
    expectIdle("R2 reset");
    loadBar(0, 24'h000000);
    busCycle(24'h000000, 1'b0);
    expectIdle("R2 flags clear");
  endtask

  // R1, R9: staged commit and staging reuse
  task automatic t_commit();
    cfgWrite(ST_LO, 8'h34);
    cfgWrite(ST_MID, 8'h12);
    setEn(3, 1'b1);
    busCycle(24'hAB1234, 1'b0);
    expectIdle("R1 no commit yet");
    cfgWrite(3, 8'hAB);
    busCycle(24'hAB1234, 1'b0);
    expectBreak("R1 commit", 3);
    clearBreak();
    cfgWrite(7, 8'hCD);
    setEn(7, 1'b1);
    busCycle(24'hCD1234, 1'b0);
    expectBreak("R9 staging reuse", 7);
    clearBreak();
  endtask

  // R4: strobe, full compare
  task automatic t_compare();
    busCycle(24'hAB1235, 1'b0);
    expectIdle("R4 bit0 differs");
    busCycle(24'h2B1234, 1'b0);
    expectIdle("R4 bit23 differs");
    @(negedge clk);
    busAddr = 24'hAB1234; busValid = 1'b0;
    @(negedge clk);
    expectIdle("R4 no strobe");
  endtask

  // R3: single enable flag write
  task automatic t_enable();
    setEn(3, 1'b0);
    busCycle(24'hAB1234, 1'b0);
    expectIdle("R3 flag off");
    busCycle(24'hCD1234, 1'b0);
    expectBreak("R3 neighbour kept", 7);
    clearBreak();
    setEn(7, 1'b0);
  endtask

  // R6, R5: priority and index end values
  task automatic t_priority();
    loadBar(20, 24'h445566);
    loadBar(10, 24'h445566);
    setEn(20, 1'b1);
    setEn(10, 1'b1);
    busCycle(24'h445566, 1'b0);
    expectBreak("R6 lowest wins", 10);
    clearBreak();
    loadBar(31, 24'h0000FF);
    setEn(31, 1'b1);
    busCycle(24'h0000FF, 1'b1);
    expectBreak("R5 index 31", 31);
  endtask

  // R7: sticky capture
  task automatic t_sticky();
    setEn(0, 1'b1);
    busCycle(24'h000000, 1'b0);
    expectBreak("R7 held", 31);
    clearBreak();
    busCycle(24'h000000, 1'b0);
    expectBreak("R5 index 0", 0);
  endtask

  // R8: partial decode read and clear
  task automatic t_clear();
    logic [7:0] v;
    busCycle(24'hFFFF00, 1'b0);
    expectBreak("R8 write no clear", 0);
    readStatus(24'hFFFE00, v);
    expectBreak("R8 other page", 0);
    busCycle(24'h445566, 1'b0);
    readStatus(24'hFFFF23, v);
    check(v === 8'h00, "R8 read value", int'(v), 0);
    expectIdle("R8 cleared");
    busCycle(24'h445566, 1'b0);
    readStatus(24'hFFFF80, v);
    check(v === 8'h0A, "R8 read value 10", int'(v), 10);
    expectIdle("R8 cleared again");
    loadBar(2, 24'hFFFF40);
    setEn(2, 1'b1);
    readStatus(24'hFFFF40, v);
    expectIdle("R8 no capture on read");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_commit();
    t_compare();
    t_enable();
    t_priority();
    t_sticky();
    t_clear();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule